// File: doc/BRIEF.md
# Modem Control Register with Local Loopback

This block holds the five-bit modem control register of one serial channel. The CPU writes it through a simple write strobe and reads it back at any time. In normal operation, two of the bits drive the active-low data-terminal-ready and request-to-send pins. A third bit decides whether the interrupt pin is driven or released to high impedance. The serial data and the four incoming modem lines pass straight through to the channel's receiver and its status logic.

Setting the loopback bit turns the block into a diagnostic loop. The serial output pin sits at mark and the transmitter's bit stream is fed back to the receiver. The external ready and request pins go inactive. The status logic then sees the register's own bits instead of the external modem lines: ready feeds data-set-ready, request feeds clear-to-send, one bit stands in for ring indicator and another for carrier detect. That last bit therefore has two jobs. It gates the interrupt pin in normal mode and supplies carrier detect in loopback.

Top module: `mdm_ctrl_loop`

## Requirements
- R1: After reset the register reads 0, `dtr_n_pin` and `rts_n_pin` are 1, `irq_oe` is 0 and `irq_out` is 0.
- R2: A clock edge with `wr_en` high loads `wr_data[4:0]` into the register, which `rd_data[4:0]` shows from that edge on. Without `wr_en` the register keeps its value. `rd_data[7:5]` always reads 0, even after a write of ones there.
- R3: Outside loopback, register bit 0 (weight 1) set drives `dtr_n_pin` to 0, and bit 0 clear drives it to 1.
- R4: Outside loopback, register bit 1 (weight 2) set drives `rts_n_pin` to 0, and bit 1 clear drives it to 1.
- R5: Outside loopback, `irq_oe` equals register bit 3 (weight 8). While `irq_oe` is 1, `irq_out` follows `irq_req`. While `irq_oe` is 0, `irq_out` is 0.
- R6: Outside loopback, `sout` equals `tx_serial`, `rx_serial` equals `sin`, and each internal modem line (`cts_n_int`, `dsr_n_int`, `ri_n_int`, `dcd_n_int`) equals its pin input.
- R7: With register bit 4 (weight 16) set, `sout` is 1, `rx_serial` equals `tx_serial`, `dtr_n_pin` and `rts_n_pin` are 1, and `irq_oe` is 0.
- R8: In loopback, `dsr_n_int` is the inverse of bit 0, `cts_n_int` of bit 1, `ri_n_int` of bit 2 and `dcd_n_int` of bit 3. The four modem pin inputs and `sin` have no effect.
- R9: Outside loopback, register bit 2 has no effect on any output other than `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data from the CPU |
| rd_data | output | 8 | Register readback, upper bits zero |
| tx_serial | input | 1 | Bit stream from the transmitter |
| sout | output | 1 | Serial output pin |
| sin | input | 1 | Serial input pin |
| rx_serial | output | 1 | Bit stream to the receiver |
| dtr_n_pin | output | 1 | Data terminal ready pin, active low |
| rts_n_pin | output | 1 | Request to send pin, active low |
| cts_n_pin | input | 1 | Clear to send pin, active low |
| dsr_n_pin | input | 1 | Data set ready pin, active low |
| ri_n_pin | input | 1 | Ring indicator pin, active low |
| dcd_n_pin | input | 1 | Carrier detect pin, active low |
| cts_n_int | output | 1 | Clear to send seen by status logic |
| dsr_n_int | output | 1 | Data set ready seen by status logic |
| ri_n_int | output | 1 | Ring indicator seen by status logic |
| dcd_n_int | output | 1 | Carrier detect seen by status logic |
| irq_req | input | 1 | Interrupt request from the channel |
| irq_out | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench sets bit 3 in both modes. This catches a design that keeps the interrupt pin enabled in loopback or that fails to drive carrier detect from that bit. It wiggles every external modem pin and `sin` while loopback is on. A mux that leaked the outside world through would show up as a changed internal line. It writes ones into the unused upper bits, which a register stored at full width would echo back. It also checks that ring-indicator bit 2 moves no pin in normal mode, and that a missing polarity inversion shows up on the pins in the very cycle after a write.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // Register bit positions; the loopback mux relies on bits 0..3 lining up
   // with the internal modem line order below.
   localparam int unsigned CTL_DTR  = 0;
   localparam int unsigned CTL_RTS  = 1;
   localparam int unsigned CTL_RI   = 2;
   localparam int unsigned CTL_AUX  = 3;
   localparam int unsigned CTL_LOOP = 4;
   localparam int unsigned CTL_BITS = 5;

   // Internal modem line order: index i is looped from register bit i.
   localparam int unsigned LN_DSR = 0;
   localparam int unsigned LN_CTS = 1;
   localparam int unsigned LN_RI  = 2;
   localparam int unsigned LN_DCD = 3;
   localparam int unsigned LN_CNT = 4;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
   import mdm_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned CTRL_W = CTL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [CTRL_W-1:0] ctrl,
   output logic [BUS_W-1:0]  rd_data
);
   localparam int unsigned PAD_W = BUS_W - CTRL_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl <= '0;
      else if (wr_en) ctrl <= wr_data[CTRL_W-1:0];
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, ctrl};
      end else begin : g_nopad
         assign rd_data = ctrl;
      end
   endgenerate
endmodule

// File: rtl/mdm_loop_mux.sv
module mdm_loop_mux
   import mdm_pkg::*;
#(
   parameter int unsigned LINES = LN_CNT
) (
   input  logic             loop_en,
   input  logic [LINES-1:0] ctl_lines,
   input  logic [LINES-1:0] pin_lines_n,
   output logic [LINES-1:0] int_lines_n,
   input  logic             tx_serial,
   input  logic             sin,
   output logic             sout,
   output logic             rx_serial
);
   genvar i;
   generate
      for (i = 0; i < LINES; i++) begin : g_line
         assign int_lines_n[i] = loop_en ? ~ctl_lines[i] : pin_lines_n[i];
      end
   endgenerate

   assign sout      = loop_en ? 1'b1 : tx_serial;
   assign rx_serial = loop_en ? tx_serial : sin;
endmodule

// File: rtl/mdm_pin_drive.sv
module mdm_pin_drive #(
   parameter int unsigned OUT_LINES = 2,
   parameter bit          IRQ_IDLE  = 1'b0
) (
   input  logic                 loop_en,
   input  logic [OUT_LINES-1:0] ctl_out,
   input  logic                 irq_gate,
   input  logic                 irq_req,
   output logic [OUT_LINES-1:0] pins_n,
   output logic                 irq_out,
   output logic                 irq_oe
);
   genvar i;
   generate
      for (i = 0; i < OUT_LINES; i++) begin : g_out
         assign pins_n[i] = loop_en | ~ctl_out[i];
      end
   endgenerate

   assign irq_oe  = irq_gate & ~loop_en;
   assign irq_out = irq_oe ? irq_req : IRQ_IDLE;
endmodule

// File: rtl/mdm_ctrl_loop.sv
module mdm_ctrl_loop
   import mdm_pkg::*;
#(
   parameter int unsigned BUS_W    = 8,
   parameter int unsigned CTRL_W   = CTL_BITS,
   parameter bit          IRQ_IDLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   input  logic             tx_serial,
   output logic             sout,
   input  logic             sin,
   output logic             rx_serial,
   output logic             dtr_n_pin,
   output logic             rts_n_pin,
   input  logic             cts_n_pin,
   input  logic             dsr_n_pin,
   input  logic             ri_n_pin,
   input  logic             dcd_n_pin,
   output logic             cts_n_int,
   output logic             dsr_n_int,
   output logic             ri_n_int,
   output logic             dcd_n_int,
   input  logic             irq_req,
   output logic             irq_out,
   output logic             irq_oe
);
   generate
      if (CTRL_W != CTL_BITS) begin : g_bad_ctrl
         $error("mdm_ctrl_loop: CTRL_W must equal CTL_BITS");
      end
      if (BUS_W < CTRL_W) begin : g_bad_bus
         $error("mdm_ctrl_loop: BUS_W narrower than CTRL_W");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic [LN_CNT-1:0] pin_lines_n;
   logic [LN_CNT-1:0] int_lines_n;
   logic [1:0]        out_pins_n;
   logic              loop_en;

   assign loop_en = ctrl[CTL_LOOP];

   mdm_ctrl_reg #(.BUS_W(BUS_W), .CTRL_W(CTRL_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctrl    (ctrl),
      .rd_data (rd_data)
   );

   always_comb begin
      pin_lines_n         = '0;
      pin_lines_n[LN_DSR] = dsr_n_pin;
      pin_lines_n[LN_CTS] = cts_n_pin;
      pin_lines_n[LN_RI]  = ri_n_pin;
      pin_lines_n[LN_DCD] = dcd_n_pin;
   end

   mdm_loop_mux #(.LINES(LN_CNT)) u_mux (
      .loop_en     (loop_en),
      .ctl_lines   (ctrl[LN_CNT-1:0]),
      .pin_lines_n (pin_lines_n),
      .int_lines_n (int_lines_n),
      .tx_serial   (tx_serial),
      .sin         (sin),
      .sout        (sout),
      .rx_serial   (rx_serial)
   );

   assign dsr_n_int = int_lines_n[LN_DSR];
   assign cts_n_int = int_lines_n[LN_CTS];
   assign ri_n_int  = int_lines_n[LN_RI];
   assign dcd_n_int = int_lines_n[LN_DCD];

   mdm_pin_drive #(.OUT_LINES(2), .IRQ_IDLE(IRQ_IDLE)) u_drv (
      .loop_en  (loop_en),
      .ctl_out  ({ctrl[CTL_RTS], ctrl[CTL_DTR]}),
      .irq_gate (ctrl[CTL_AUX]),
      .irq_req  (irq_req),
      .pins_n   (out_pins_n),
      .irq_out  (irq_out),
      .irq_oe   (irq_oe)
   );

   assign dtr_n_pin = out_pins_n[0];
   assign rts_n_pin = out_pins_n[1];
endmodule

// File: rtl/mdm_ctrl_chk.sv
module mdm_ctrl_chk #(
   parameter int unsigned BUS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [BUS_W-1:0] wr_data,
   input logic [BUS_W-1:0] rd_data,
   input logic             tx_serial,
   input logic             sout,
   input logic             sin,
   input logic             rx_serial,
   input logic             dtr_n_pin,
   input logic             rts_n_pin,
   input logic             cts_n_pin,
   input logic             dsr_n_pin,
   input logic             ri_n_pin,
   input logic             dcd_n_pin,
   input logic             cts_n_int,
   input logic             dsr_n_int,
   input logic             ri_n_int,
   input logic             dcd_n_int,
   input logic             irq_req,
   input logic             irq_out,
   input logic             irq_oe
);
   AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[4:0] == $past(wr_data[4:0])); // R2
   AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data)); // R2
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[BUS_W-1:5] == '0); // R2
   AST_DTR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[4] |-> dtr_n_pin == !rd_data[0]); // R3
   AST_RTS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[4] |-> rts_n_pin == !rd_data[1]); // R4
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_oe |-> !irq_out); // R5
   AST_LOOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] |-> (sout && rx_serial == tx_serial && dtr_n_pin && rts_n_pin && !irq_oe)); // R7
   AST_LOOP_DCD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] |-> dcd_n_int == !rd_data[3]); // R8
   AST_PASS_SIN: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[4] |-> (rx_serial == sin && sout == tx_serial)); // R6
endmodule

bind mdm_ctrl_loop mdm_ctrl_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/tb_mdm_ctrl_loop.sv
`timescale 1ns/1ps
module tb_mdm_ctrl_loop;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       tx_serial = 1'b1, sin = 1'b1;
   logic       sout, rx_serial, dtr_n_pin, rts_n_pin;
   logic       cts_n_pin = 1'b1, dsr_n_pin = 1'b1, ri_n_pin = 1'b1, dcd_n_pin = 1'b1;
   logic       cts_n_int, dsr_n_int, ri_n_int, dcd_n_int;
   logic       irq_req = 1'b0, irq_out, irq_oe;
   int         total = 0, bad = 0;

   always #5 clk = ~clk;

   mdm_ctrl_loop dut (.*);

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1 rd", rd_data, 8'h00);
      chk("R1 dtr", {7'd0, dtr_n_pin}, 8'd1);
      chk("R1 rts", {7'd0, rts_n_pin}, 8'd1);
      chk("R1 oe", {7'd0, irq_oe}, 8'd0);
      chk("R1 irq", {7'd0, irq_out}, 8'd0);
   endtask

   task automatic t_write();
      wr(8'hFF);
      chk("R2 upper zero", rd_data, 8'h1F);
      @(negedge clk); wr_data = 8'h00; #1;
      @(negedge clk); #1;
      chk("R2 hold", rd_data, 8'h1F);
      wr(8'h00);
      chk("R2 clear", rd_data, 8'h00);
   endtask

   task automatic t_dtr_rts();
      wr(8'h01);
      chk("R3 dtr low", {6'd0, rts_n_pin, dtr_n_pin}, 8'b10);
      wr(8'h02);
      chk("R4 rts low", {6'd0, rts_n_pin, dtr_n_pin}, 8'b01);
      wr(8'h03);
      chk("R3 R4 both", {6'd0, rts_n_pin, dtr_n_pin}, 8'b00);
   endtask

   task automatic t_irq();
      wr(8'h00);
      irq_req = 1'b1; #1;
      chk("R5 gated", {6'd0, irq_oe, irq_out}, 8'b00);
      wr(8'h08);
      chk("R5 enabled", {6'd0, irq_oe, irq_out}, 8'b11);
      irq_req = 1'b0; #1;
      chk("R5 follow", {6'd0, irq_oe, irq_out}, 8'b10);
   endtask

   task automatic t_pass();
      wr(8'h08);
      tx_serial = 1'b0; sin = 1'b1;
      {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin} = 4'b0101; #1;
      chk("R6 serial", {6'd0, sout, rx_serial}, 8'b01);
      chk("R6 modem", {4'd0, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int}, 8'h05);
      tx_serial = 1'b1; sin = 1'b0;
      {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin} = 4'b1010; #1;
      chk("R6 serial2", {6'd0, sout, rx_serial}, 8'b10);
      chk("R6 modem2", {4'd0, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int}, 8'h0A);
   endtask

   task automatic t_loop();
      wr(8'h1B);
      tx_serial = 1'b0; sin = 1'b1; irq_req = 1'b1; #1;
      chk("R7 mark", {6'd0, sout, rx_serial}, 8'b10);
      chk("R7 pins", {5'd0, rts_n_pin, dtr_n_pin, irq_oe}, 8'b110);
      chk("R7 irq", {7'd0, irq_out}, 8'd0);
      tx_serial = 1'b1; sin = 1'b0; #1;
      chk("R7 echo", {6'd0, sout, rx_serial}, 8'b11);
      irq_req = 1'b0;
   endtask

   task automatic t_loop_modem();
      wr(8'h15);
      {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin} = 4'b0000; #1;
      chk("R8 5", {4'd0, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int}, 8'h0A);
      {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin} = 4'b1111; #1;
      chk("R8 pins ignored", {4'd0, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int}, 8'h0A);
      wr(8'h1A);
      chk("R8 A", {4'd0, dcd_n_int, ri_n_int, cts_n_int, dsr_n_int}, 8'h05);
      wr(8'h18);
      chk("R8 dcd", {7'd0, dcd_n_int}, 8'd0);
   endtask

   task automatic t_bit2();
      wr(8'h00);
      tx_serial = 1'b0; sin = 1'b1; irq_req = 1'b1;
      {dcd_n_pin, ri_n_pin, cts_n_pin, dsr_n_pin} = 4'b1111; #1;
      wr(8'h04);
      chk("R9 rd", rd_data, 8'h04);
      chk("R9 outs", {sout, rx_serial, dtr_n_pin, rts_n_pin, irq_oe, irq_out, ri_n_int, dcd_n_int},
          8'b01110011);
   endtask

   initial begin
      #1;
      chk("R1 rd in reset", rd_data, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_write();
      t_dtr_rts();
      t_irq();
      t_pass();
      t_loop();
      t_loop_modem();
      t_bit2();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule